// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external 64K x 8 asynchronous static RAM. The host presents one request at a time: a write flag, a 16-bit address and, for writes, a byte of data. The controller latches the request and produces the device strobes in a timed sequence: an active-low chip enable, an active-high chip enable, an output enable and a write enable. It also provides a write-data bus with a drive-enable for the bidirectional data pins. It ends each access with a one-cycle done pulse. For reads, the returned byte appears on the host read-data port at that pulse.

Every device timing figure is a nanosecond parameter. Each is converted to a whole number of clock cycles by rounding up the quotient by the clock-period parameter. With a 5 ns clock and the default figures, the counts are as follows:

- The read window is 17 cycles, the largest of the 85 ns cycle time, the 85 ns address access and the 40 ns output-enable access.
- The write-enable pulse is 14 cycles, the largest of the 60 ns pulse width, the 70 ns address-to-end-of-write and the 35 ns data setup.
- The write recovery is 3 cycles, topping the access up to the 85 ns write cycle and covering the 5 ns recovery.

The address setup before the write pulse is 0 ns by default, so the setup state is skipped.

The controller is a six-state machine:

| State | Role |
|---|---|
| ST_IDLE | Ready; device deselected |
| ST_RD_ACC | Read window |
| ST_WR_SETUP | Address setup, entered only when the setup count is nonzero |
| ST_WR_PULSE | Write-enable pulse |
| ST_WR_RECOV | Recovery; write enable high, selection and data held |
| ST_FINISH | Done cycle; device deselected |

The transitions are:

- ST_IDLE to ST_RD_ACC on a read request.
- ST_IDLE to ST_WR_SETUP, or directly to ST_WR_PULSE, on a write request.
- ST_WR_SETUP to ST_WR_PULSE when its timer expires.
- ST_WR_PULSE to ST_WR_RECOV when its timer expires.
- ST_RD_ACC or ST_WR_RECOV to ST_FINISH when the timer expires. Read data is captured on the edge that leaves ST_RD_ACC.
- ST_FINISH to ST_IDLE unconditionally.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle, host_ready is 1 and host_done is 0. The device is deselected in this state: mem_ce_n=1, mem_ce=0, mem_oe_n=1, mem_we_n=1 and mem_dout_en=0.
- R2: A read holds mem_ce_n=0, mem_ce=1, mem_oe_n=0 and mem_we_n=1 for exactly the read window. With the defaults this window is 17 cycles. It starts in the cycle after the edge that accepts the request, and mem_dout_en stays 0 throughout.
- R3: host_rdata takes the value of mem_din sampled on the last edge of the read window. host_rdata changes at no other time.
- R4: During a write, mem_we_n is low for exactly the pulse count, which is 14 cycles with the defaults. mem_we_n is low only while mem_ce_n=0 and mem_ce=1, and mem_oe_n stays 1 for the whole write.
- R5: mem_dout_en is 1 exactly while mem_we_n is low and during the recovery cycles, which makes 17 cycles with the defaults. mem_dout is constant throughout and equals the host write data latched at acceptance.
- R6: After mem_we_n rises, both chip enables and mem_addr are held for the recovery count, which is 3 cycles with the defaults. mem_addr is constant and equal to the accepted host address while the device is selected.
- R7: Each access ends with host_done high for exactly one cycle, with the device deselected. This cycle follows the last access cycle, so the edge-to-done latency is 18 cycles for both a read and a write at the defaults. host_ready returns to 1 in the next cycle.
- R8: A request is accepted only on an edge where host_ready is 1. A request held while host_ready is 0 and withdrawn before ready returns starts no access and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, taken when host_ready is 1 |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Controller idle and able to accept |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last byte read |
| mem_addr | output | 16 | Device address bus |
| mem_dout | output | 8 | Byte driven toward the device |
| mem_dout_en | output | 1 | Drive enable for the data pins |
| mem_din | input | 8 | Byte returned by the device |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |

## Verification
The bench models the device as a byte store. The store latches on the rising write enable, and its read value depends on both address bytes. Each check targets a specific error:

- A window shortened by one cycle shows up as a wrong output-enable or write-enable length.
- Data captured an edge early or late shows up as a wrong read byte.
- A recovery that drops the selection together with write enable shows up as a short recovery count.

The bench writes and reads back a sweep of addresses that includes 0x0000 and 0xFFFF, so a dropped or swapped address bit returns the wrong byte. It also holds a write request through a busy read. A controller that wrongly latches that request writes an extra byte or starts a spurious selection.

// File: rtl/sctl_pkg.sv
`timescale 1ns/1ps
package sctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_FINISH
    } sctl_state_e;

    // Round a nanosecond figure up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sctl_timer.sv
`timescale 1ns/1ps
module sctl_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sctl_datapath.sv
`timescale 1ns/1ps
module sctl_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] in_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= in_rdata;
        end
    end

endmodule

// File: rtl/sctl_fsm.sv
`timescale 1ns/1ps
module sctl_fsm
    import sctl_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int RD_CYC  = 17,
    parameter int AS_CYC  = 0,
    parameter int WP_CYC  = 14,
    parameter int REC_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             write,
    input  logic             tmr_expired,
    output sctl_state_e      state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture
);

    localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_AS  = CNT_W'((AS_CYC > 0) ? AS_CYC - 1 : 0);
    localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_REC = CNT_W'(REC_CYC - 1);

    sctl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    if (!write)          state_d = ST_RD_ACC;
                    else if (AS_CYC > 0) state_d = ST_WR_SETUP;
                    else                 state_d = ST_WR_PULSE;
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) begin
                    capture = 1'b1;
                    state_d = ST_FINISH;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_expired) state_d = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                if (tmr_expired) state_d = ST_WR_RECOV;
            end
            ST_WR_RECOV: begin
                if (tmr_expired) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Timer reload on every state entry, with the count of the state entered.
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_RD_ACC:   tmr_val = LD_RD;
            ST_WR_SETUP: tmr_val = LD_AS;
            ST_WR_PULSE: tmr_val = LD_WP;
            ST_WR_RECOV: tmr_val = LD_REC;
            default:     tmr_val = '0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sctl_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_RC_NS       = 85,
    parameter int T_AA_NS       = 85,
    parameter int T_OE_NS       = 40,
    parameter int T_WC_NS       = 85,
    parameter int T_AW_NS       = 70,
    parameter int T_WP_NS       = 60,
    parameter int T_AS_NS       = 0,
    parameter int T_DW_NS       = 35,
    parameter int T_WR_NS       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam int RD_CYC  = imax(1, imax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                  imax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                       ns_to_cyc(T_OE_NS, CLK_PERIOD_NS))));
    localparam int AS_CYC  = ns_to_cyc(T_AS_NS, CLK_PERIOD_NS);
    localparam int WP_CYC  = imax(1, imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                  imax(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS) - AS_CYC,
                                       ns_to_cyc(T_DW_NS, CLK_PERIOD_NS))));
    localparam int REC_CYC = imax(1, imax(ns_to_cyc(T_WR_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - AS_CYC - WP_CYC));
    localparam int MAX_CYC = imax(imax(RD_CYC, AS_CYC), imax(WP_CYC, REC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    sctl_state_e      state;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             capture;
    logic [DATA_W-1:0] wdata_q;

    sctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sctl_fsm #(
        .CNT_W   (CNT_W),
        .RD_CYC  (RD_CYC),
        .AS_CYC  (AS_CYC),
        .WP_CYC  (WP_CYC),
        .REC_CYC (REC_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (host_req),
        .write       (host_write),
        .tmr_expired (tmr_expired),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .accept      (accept),
        .capture     (capture)
    );

    sctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .in_addr  (host_addr),
        .in_wdata (host_wdata),
        .in_rdata (mem_din),
        .addr_q   (mem_addr),
        .wdata_q  (wdata_q),
        .rdata_q  (host_rdata)
    );

    assign mem_dout = wdata_q;

    // Strobe decode from the registered state.
    always_comb begin
        mem_ce_n    = 1'b1;
        mem_ce      = 1'b0;
        mem_oe_n    = 1'b1;
        mem_we_n    = 1'b1;
        mem_dout_en = 1'b0;
        host_ready  = 1'b0;
        host_done   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                host_ready = 1'b1;
            end
            ST_RD_ACC: begin
                mem_ce_n = 1'b0;
                mem_ce   = 1'b1;
                mem_oe_n = 1'b0;
            end
            ST_WR_SETUP: begin
                mem_ce_n = 1'b0;
                mem_ce   = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_ce_n    = 1'b0;
                mem_ce      = 1'b1;
                mem_we_n    = 1'b0;
                mem_dout_en = 1'b1;
            end
            ST_WR_RECOV: begin
                mem_ce_n    = 1'b0;
                mem_ce      = 1'b1;
                mem_dout_en = 1'b1;
            end
            ST_FINISH: begin
                host_done = 1'b1;
            end
            default: begin
                host_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sctl_checker.sv
`timescale 1ns/1ps
module sctl_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RD_CYC = 17,
    parameter int WP_CYC = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_ready,
    input logic              host_done,
    input logic [DATA_W-1:0] host_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en,
    input logic [DATA_W-1:0] mem_din,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_oe_n,
    input logic              mem_we_n
);

    logic [15:0] oe_lo_cnt;
    logic [15:0] we_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_lo_cnt <= '0;
            we_lo_cnt <= '0;
        end else begin
            oe_lo_cnt <= mem_oe_n ? 16'd0 : oe_lo_cnt + 16'd1;
            we_lo_cnt <= mem_we_n ? 16'd0 : we_lo_cnt + 16'd1;
        end
    end

    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dout_en && !host_done));

    assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_ce && mem_we_n && !mem_dout_en));

    assert_read_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_lo_cnt == 16'(RD_CYC)));

    assert_rdata_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (host_rdata == $past(mem_din)));

    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(host_rdata) |-> ($past(!mem_oe_n) && mem_oe_n));

    assert_write_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n && mem_dout_en));

    assert_write_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt == 16'(WP_CYC)));

    assert_dout_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout));

    assert_recovery_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_ce && mem_dout_en));

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> (!host_done && host_ready));

    assert_done_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (mem_ce_n && !mem_ce));

    assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> $past(host_ready && host_req));

endmodule

bind sram_async_ctrl sctl_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC)
) u_chk (.*);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

    function automatic int cdiv(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    localparam int PER    = 5;
    localparam int EXP_RD = cdiv(85, PER);                 // 17
    localparam int EXP_WP = cdiv(70, PER);                 // 14 (address-to-end dominates)
    localparam int EXP_RC = cdiv(85, PER) - EXP_WP;        // 3
    localparam int EXP_LAT = EXP_RD + 1;                   // 18

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_done;
    logic [7:0]  host_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_dout;
    logic        mem_dout_en;
    logic [7:0]  mem_din;
    logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n;

    always #2.5 clk = ~clk;

    sram_async_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    int checks = 0;
    int errors = 0;

    // Device model: byte store indexed by the low address byte; read value also folds in the high byte.
    logic [7:0] model_mem [0:255];
    logic [7:0] ref_mem   [0:255];
    initial begin
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = 8'(i) ^ 8'h3C;
            ref_mem[i]   = 8'(i) ^ 8'h3C;
        end
    end

    assign mem_din = (!mem_ce_n && mem_ce && !mem_oe_n)
                     ? (model_mem[mem_addr[7:0]] ^ mem_addr[15:8]) : 8'hEE;

    // Negedge monitor of the device strobes.
    int oe_cnt = 0, last_oe = 0;
    int we_cnt = 0, last_we = 0;
    int den_cnt = 0, last_den = 0;
    int rec_cnt = 0, last_rec = 0;
    bit in_rec = 0;
    int write_events = 0;
    int select_starts = 0;
    int addr_moves = 0;
    int oe_in_write = 0;
    int done_double = 0;
    logic [15:0] wr_addr_seen;
    logic [7:0]  wr_data_seen;
    logic prev_we_n = 1, prev_oe_n = 1, prev_den = 0, prev_ce_n = 1, prev_done = 0;
    logic [15:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n && prev_ce_n) select_starts++;
            if (!mem_ce_n && !prev_ce_n && mem_addr != prev_addr) addr_moves++;
            if (!mem_oe_n && mem_dout_en) oe_in_write++;
            if (host_done && prev_done) done_double++;
            if (!mem_oe_n) oe_cnt++;
            else if (!prev_oe_n) begin last_oe = oe_cnt; oe_cnt = 0; end
            if (mem_dout_en) den_cnt++;
            else if (prev_den) begin last_den = den_cnt; den_cnt = 0; end
            if (in_rec) begin
                if (!mem_ce_n) rec_cnt++;
                else begin last_rec = rec_cnt; in_rec = 0; end
            end
            if (!mem_we_n) begin
                we_cnt++;
                wr_data_seen = mem_dout;
                if (!mem_oe_n) oe_in_write++;
            end else if (!prev_we_n) begin
                last_we = we_cnt; we_cnt = 0;
                wr_addr_seen = mem_addr;
                if (!mem_ce_n && mem_ce) begin
                    model_mem[mem_addr[7:0]] = wr_data_seen;
                    write_events++;
                end
                in_rec = 1; rec_cnt = 1;
            end
            prev_we_n = mem_we_n; prev_oe_n = mem_oe_n; prev_den = mem_dout_en;
            prev_ce_n = mem_ce_n; prev_done = host_done; prev_addr = mem_addr;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d, output int lat);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_addr = ~a; host_wdata = ~d;
        lat = 1;
        while (!host_done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        #1;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        int lat;
        int ev0;
        ev0 = write_events;
        access(1'b1, a, d, lat);
        ref_mem[a[7:0]] = d;
        check(lat == EXP_LAT, "R7 write latency", lat, EXP_LAT);
        check(last_we == EXP_WP, "R4 write pulse length", last_we, EXP_WP);
        check(last_rec == EXP_RC, "R6 recovery length", last_rec, EXP_RC);
        check(last_den == EXP_WP + EXP_RC, "R5 drive length", last_den, EXP_WP + EXP_RC);
        check(write_events == ev0 + 1, "R4 one write per access", write_events, ev0 + 1);
        check(wr_addr_seen == a, "R6 write address", int'(wr_addr_seen), int'(a));
        check(wr_data_seen == d, "R5 write data", int'(wr_data_seen), int'(d));
    endtask

    task automatic do_read(input logic [15:0] a);
        int lat;
        logic [7:0] exp;
        exp = ref_mem[a[7:0]] ^ a[15:8];
        access(1'b0, a, 8'h00, lat);
        check(lat == EXP_LAT, "R7 read latency", lat, EXP_LAT);
        check(last_oe == EXP_RD, "R2 read window length", last_oe, EXP_RD);
        check(host_rdata == exp, "R3 read data", int'(host_rdata), int'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] held;
        int starts0, ev0, lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(host_ready && !host_done, "R1 ready after reset", {host_ready, host_done}, 2'b10);
        check({mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dout_en} == 5'b10110,
              "R1 deselected in reset", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dout_en}, 5'b10110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dout_en} == 5'b10110,
              "R1 deselected when idle", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dout_en}, 5'b10110);

        // Boundary addresses
        do_write(16'h0000, 8'hA1);
        do_write(16'hFFFF, 8'h5E);
        do_read(16'h0000);
        do_read(16'hFFFF);

        // Sweep: unique low bytes, varied high bytes
        for (int i = 0; i < 32; i++) begin
            do_write({8'(i * 37) ^ 8'hA5, 8'(i * 8 + 3)}, 8'(i * 29 + 11));
        end
        for (int i = 0; i < 32; i++) begin
            do_read({8'(i * 37) ^ 8'hA5, 8'(i * 8 + 3)});
        end
        // Read of untouched location, then check R3 hold across a write
        do_read(16'h1206);
        held = host_rdata;
        do_write(16'h3307, 8'hC4);
        check(host_rdata == held, "R3 rdata held across write", int'(host_rdata), int'(held));

        // R8: write request held while a read is busy, then withdrawn
        starts0 = select_starts;
        ev0 = write_events;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_write = 1'b0; host_addr = 16'h4A0B; host_wdata = 8'h00;
        @(negedge clk);
        check(!host_ready, "R8 ready low while busy", host_ready, 0);
        host_write = 1'b1; host_addr = 16'h770B; host_wdata = 8'h99;
        repeat (5) @(negedge clk);
        host_req = 1'b0;
        lat = 6;
        while (!host_done && lat < 1000) begin @(negedge clk); lat++; end
        #1;
        check(lat == EXP_LAT, "R8 busy read latency", lat, EXP_LAT);
        check(host_rdata == (ref_mem[8'h0B] ^ 8'h4A), "R8 busy read data",
              int'(host_rdata), int'(ref_mem[8'h0B] ^ 8'h4A));
        repeat (6) @(negedge clk);
        check(select_starts == starts0 + 1, "R8 no extra access", select_starts, starts0 + 1);
        check(write_events == ev0, "R8 stalled write ignored", write_events, ev0);
        check(host_ready && mem_ce_n, "R1 idle after stall", {host_ready, mem_ce_n}, 2'b11);
        do_read(16'h000B);

        check(addr_moves == 0, "R6 address stable while selected", addr_moves, 0);
        check(oe_in_write == 0, "R4 output enable high in write", oe_in_write, 0);
        check(done_double == 0, "R7 done single cycle", done_double, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule